// File: doc/BRIEF.md
# Token-Passing Sparse Hit Readout for a Pixel Column

The block sits at the base of one pixel column and drains the hits held by a chain of local controllers. Each controller looks after a group of pixels and presents its buffered hits one at a time: a pixel offset within its group and a timestamp. Only the controller that currently owns a single circulating token may hand over hits. When it has none left, the token moves to the next controller. Pixels without hits cost no readout cycles.

Each hit taken from a controller is turned into a full hit word. The block works out the absolute row from the controller's position in the chain and the reported offset. It then packs the row, a fixed column address and the timestamp into one 38-bit word. A two-stage valid/ready pipeline delivers one word per clock when the consumer keeps up. Backpressure stalls the pipeline without dropping or duplicating a hit. A start pulse begins a readout pass, and a done flag marks the end of the pass.

Top module: `tcsr_column_base`

## Requirements
- R1: The output word carries the row in bits [37:27], the column address in bits [26:16] and the timestamp in bits [15:0]. The column field always equals the parameter COL_ADDR.
- R2: The row field equals controller index × GROUP + the offset reported by that controller. The controller index runs from 0 at the first controller in the chain.
- R3: Hits are taken only from the controller that holds the token, and only while that controller shows a pending hit. At most one hit is taken per clock. Every hit of controller i is emitted before any hit of controller i+1. Each controller's hits keep their own order.
- R4: A token holder with no pending hit passes the token to the next controller on the following clock edge. With every controller empty, done rises exactly N_CTRL clock edges after the edge that samples start.
- R5: With the consumer always ready and one controller holding several hits, the hit words leave on consecutive clocks.
- R6: While hit_valid_o is high and hit_ready_i is low, hit_valid_o stays high and hit_word_o holds its value. Under any pattern of ready, every hit appears exactly once.
- R7: On a clock edge where start_i is high and no controller holds the token, the token is placed at controller 0 and done is cleared. The done flag rises once the last controller has passed the token on and the pipeline is empty. Done then stays high until the next accepted start. A start pulse while the token is in the chain has no effect.
- R8: After reset, no hit is valid, no controller is popped and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a readout pass |
| ctrl_hit_valid_i | input | N_CTRL | Controller i has a pending hit |
| ctrl_ofs_i | input | N_CTRL*OFS_W | Pixel offset of each controller's head hit, controller i at [i*OFS_W +: OFS_W] |
| ctrl_ts_i | input | N_CTRL*16 | Timestamp of each controller's head hit, controller i at [i*16 +: 16] |
| ctrl_pop_o | output | N_CTRL | Head hit of controller i is taken on this edge |
| hit_valid_o | output | 1 | Output hit word is valid |
| hit_ready_i | input | 1 | Consumer accepts the hit word |
| hit_word_o | output | 38 | Packed row, column and timestamp |
| done_o | output | 1 | Readout pass complete |

## Verification
Directed passes load the controller queues in different shapes and compare the emitted words, in order, against words rebuilt from the queue contents. The shapes are a single hit, hits spread across the chain with empty controllers between them, a long burst from one controller, and offsets at both ends of a group. These tell apart wrong row arithmetic, wrong token order, skipped empty controllers and lost or repeated hits. The consumer's ready is held high, toggled in a fixed pattern, and driven pseudo-randomly. Comparing these runs separates the full-rate path from stall handling. An all-empty pass measures the token walk time. A start pulse injected mid-pass shows whether the token is wrongly reseeded.

// File: rtl/tcsr_pkg.sv
package tcsr_pkg;
  localparam int ROW_W  = 11;
  localparam int COL_W  = 11;
  localparam int TS_W   = 16;
  localparam int WORD_W = ROW_W + COL_W + TS_W;
  localparam int TS_LSB  = 0;
  localparam int COL_LSB = TS_W;
  localparam int ROW_LSB = TS_W + COL_W;

  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [COL_W-1:0]  col_t;
  typedef logic [TS_W-1:0]   ts_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t pack_hit(row_t row, col_t col, ts_t ts);
    return {row, col, ts};
  endfunction
endpackage

// File: rtl/tcsr_token_chain.sv
module tcsr_token_chain #(
  parameter int N_CTRL = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_CTRL-1:0] hit_valid_i,
  output logic [N_CTRL-1:0] tok_o,
  output logic              tok_out_o
);
  logic [N_CTRL-1:0] tok_q, pass;
  logic              tok_out_q, start_ok;

  assign pass     = tok_q & ~hit_valid_i;
  assign start_ok = start_i & ~(|tok_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q     <= '0;
      tok_out_q <= 1'b0;
    end else if (start_ok) begin
      tok_q     <= N_CTRL'(1);
      tok_out_q <= 1'b0;
    end else begin
      // holder keeps token while it has hits, otherwise shifts one place
      tok_q <= (tok_q & hit_valid_i) | {pass[N_CTRL-2:0], 1'b0};
      if (pass[N_CTRL-1]) tok_out_q <= 1'b1;
    end
  end

  assign tok_o     = tok_q;
  assign tok_out_o = tok_out_q;
endmodule

// File: rtl/tcsr_hit_select.sv
module tcsr_hit_select
  import tcsr_pkg::*;
#(
  parameter int N_CTRL = 8,
  parameter int GROUP  = 16,
  localparam int IDX_W = $clog2(N_CTRL),
  localparam int OFS_W = $clog2(GROUP)
) (
  input  logic [N_CTRL-1:0]       tok_i,
  input  logic [N_CTRL-1:0]       hit_valid_i,
  input  logic [N_CTRL*OFS_W-1:0] ofs_i,
  input  logic [N_CTRL*TS_W-1:0]  ts_i,
  input  logic                    take_i,
  output logic                    sel_valid_o,
  output logic [IDX_W-1:0]        sel_idx_o,
  output logic [OFS_W-1:0]        sel_ofs_o,
  output ts_t                     sel_ts_o,
  output logic [N_CTRL-1:0]       pop_o
);
  logic [N_CTRL-1:0] grant;

  assign grant       = tok_i & hit_valid_i;
  assign sel_valid_o = |grant;
  assign pop_o       = grant & {N_CTRL{take_i}};

  always_comb begin
    sel_idx_o = '0;
    sel_ofs_o = '0;
    sel_ts_o  = '0;
    for (int i = 0; i < N_CTRL; i++) begin
      if (grant[i]) begin
        sel_idx_o = IDX_W'(i);
        sel_ofs_o = ofs_i[i*OFS_W +: OFS_W];
        sel_ts_o  = ts_i[i*TS_W +: TS_W];
      end
    end
  end
endmodule

// File: rtl/tcsr_pipe.sv
module tcsr_pipe
  import tcsr_pkg::*;
#(
  parameter int   N_CTRL   = 8,
  parameter int   GROUP    = 16,
  parameter col_t COL_ADDR = col_t'(37),
  localparam int IDX_W = $clog2(N_CTRL),
  localparam int OFS_W = $clog2(GROUP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IDX_W-1:0] in_idx_i,
  input  logic [OFS_W-1:0] in_ofs_i,
  input  ts_t              in_ts_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output word_t            out_word_o,
  output logic             busy_o
);
  logic             s1_v, s2_v, s1_rdy, s2_rdy;
  logic [IDX_W-1:0] s1_idx;
  logic [OFS_W-1:0] s1_ofs;
  ts_t              s1_ts;
  word_t            s2_word;
  row_t             row;

  assign s2_rdy = ~s2_v | out_ready_i;
  assign s1_rdy = ~s1_v | s2_rdy;
  assign row    = row_t'(s1_idx) * row_t'(GROUP) + row_t'(s1_ofs);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_idx <= '0;
      s1_ofs <= '0;
      s1_ts  <= '0;
    end else if (s1_rdy) begin
      s1_v <= in_valid_i;
      if (in_valid_i) begin
        s1_idx <= in_idx_i;
        s1_ofs <= in_ofs_i;
        s1_ts  <= in_ts_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v    <= 1'b0;
      s2_word <= '0;
    end else if (s2_rdy) begin
      s2_v <= s1_v;
      if (s1_v) s2_word <= pack_hit(row, COL_ADDR, s1_ts);
    end
  end

  assign in_ready_o  = s1_rdy;
  assign out_valid_o = s2_v;
  assign out_word_o  = s2_word;
  assign busy_o      = s1_v | s2_v;
endmodule

// File: rtl/tcsr_column_base.sv
module tcsr_column_base
  import tcsr_pkg::*;
#(
  parameter int   N_CTRL   = 8,
  parameter int   GROUP    = 16,
  parameter col_t COL_ADDR = col_t'(37),
  localparam int IDX_W = $clog2(N_CTRL),
  localparam int OFS_W = $clog2(GROUP)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [N_CTRL-1:0]       ctrl_hit_valid_i,
  input  logic [N_CTRL*OFS_W-1:0] ctrl_ofs_i,
  input  logic [N_CTRL*TS_W-1:0]  ctrl_ts_i,
  output logic [N_CTRL-1:0]       ctrl_pop_o,
  output logic                    hit_valid_o,
  input  logic                    hit_ready_i,
  output logic [WORD_W-1:0]       hit_word_o,
  output logic                    done_o
);
  logic [N_CTRL-1:0] tok;
  logic              tok_out, sel_valid, in_ready, busy;
  logic [IDX_W-1:0]  sel_idx;
  logic [OFS_W-1:0]  sel_ofs;
  ts_t               sel_ts;

  tcsr_token_chain #(.N_CTRL(N_CTRL)) i_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .hit_valid_i (ctrl_hit_valid_i),
    .tok_o       (tok),
    .tok_out_o   (tok_out)
  );

  tcsr_hit_select #(.N_CTRL(N_CTRL), .GROUP(GROUP)) i_sel (
    .tok_i       (tok),
    .hit_valid_i (ctrl_hit_valid_i),
    .ofs_i       (ctrl_ofs_i),
    .ts_i        (ctrl_ts_i),
    .take_i      (in_ready),
    .sel_valid_o (sel_valid),
    .sel_idx_o   (sel_idx),
    .sel_ofs_o   (sel_ofs),
    .sel_ts_o    (sel_ts),
    .pop_o       (ctrl_pop_o)
  );

  tcsr_pipe #(.N_CTRL(N_CTRL), .GROUP(GROUP), .COL_ADDR(COL_ADDR)) i_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (sel_valid),
    .in_ready_o  (in_ready),
    .in_idx_i    (sel_idx),
    .in_ofs_i    (sel_ofs),
    .in_ts_i     (sel_ts),
    .out_valid_o (hit_valid_o),
    .out_ready_i (hit_ready_i),
    .out_word_o  (hit_word_o),
    .busy_o      (busy)
  );

  assign done_o = tok_out & ~busy;
endmodule

// File: rtl/tcsr_column_base_chk.sv
module tcsr_column_base_chk
  import tcsr_pkg::*;
#(
  parameter int   N_CTRL   = 8,
  parameter int   GROUP    = 16,
  parameter col_t COL_ADDR = col_t'(37)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CTRL-1:0] ctrl_hit_valid_i,
  input logic [N_CTRL-1:0] ctrl_pop_o,
  input logic [N_CTRL-1:0] tok,
  input logic              hit_valid_o,
  input logic              hit_ready_i,
  input logic [WORD_W-1:0] hit_word_o,
  input logic              done_o
);
  p_one_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_pop_o));

  p_pop_needs_token_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_pop_o & ~(tok & ctrl_hit_valid_i)) == '0);

  p_single_token_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tok));

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o && !hit_ready_i |=> hit_valid_o && $stable(hit_word_o));

  p_col_field_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> hit_word_o[ROW_LSB-1:COL_LSB] == COL_ADDR);

  p_row_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> int'(hit_word_o[WORD_W-1:ROW_LSB]) < N_CTRL * GROUP);

  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !hit_valid_o && ctrl_pop_o == '0 && tok == '0);
endmodule

bind tcsr_column_base tcsr_column_base_chk #(
  .N_CTRL(N_CTRL), .GROUP(GROUP), .COL_ADDR(COL_ADDR)
) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .ctrl_hit_valid_i (ctrl_hit_valid_i),
  .ctrl_pop_o       (ctrl_pop_o),
  .tok              (tok),
  .hit_valid_o      (hit_valid_o),
  .hit_ready_i      (hit_ready_i),
  .hit_word_o       (hit_word_o),
  .done_o           (done_o)
);

// File: tb/test_tcsr_column_base.sv
module test_tcsr_column_base;
  localparam int N     = 8;
  localparam int GROUP = 16;
  localparam int OW    = 4;
  localparam int TW    = 16;
  localparam int MAXQ  = 16;
  localparam logic [10:0] COL = 11'd37;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, hit_ready_i = 1'b1;
  logic [N-1:0]    ctrl_hit_valid_i, ctrl_pop_o;
  logic [N*OW-1:0] ctrl_ofs_i;
  logic [N*TW-1:0] ctrl_ts_i;
  logic            hit_valid_o, done_o;
  logic [37:0]     hit_word_o;

  int checks = 0, errors = 0, cyc = 0;

  logic [OW-1:0] q_ofs [N][MAXQ];
  logic [TW-1:0] q_ts  [N][MAXQ];
  int q_cnt [N];
  int q_head [N];
  logic [37:0] exp_w [N*MAXQ];
  int exp_n;

  always #2 clk_i = ~clk_i;

  tcsr_column_base #(.N_CTRL(N), .GROUP(GROUP), .COL_ADDR(COL)) i_tcsr_column_base (
    .clk_i, .rst_ni, .start_i, .ctrl_hit_valid_i, .ctrl_ofs_i, .ctrl_ts_i,
    .ctrl_pop_o, .hit_valid_o, .hit_ready_i, .hit_word_o, .done_o
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ctrl_hit_valid_i[i]         = q_head[i] < q_cnt[i];
      ctrl_ofs_i[i*OW +: OW]      = (q_head[i] < MAXQ) ? q_ofs[i][q_head[i]] : '0;
      ctrl_ts_i[i*TW +: TW]       = (q_head[i] < MAXQ) ? q_ts[i][q_head[i]] : '0;
    end
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    for (int i = 0; i < N; i++)
      if (ctrl_pop_o[i]) q_head[i] <= q_head[i] + 1;
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_queues();
    for (int i = 0; i < N; i++) begin
      q_cnt[i] = 0;
      q_head[i] = 0;
      for (int k = 0; k < MAXQ; k++) begin
        q_ofs[i][k] = '0;
        q_ts[i][k]  = '0;
      end
    end
  endtask

  task automatic add_hit(int c, logic [OW-1:0] ofs, logic [TW-1:0] ts);
    q_ofs[c][q_cnt[c]] = ofs;
    q_ts[c][q_cnt[c]]  = ts;
    q_cnt[c]++;
  endtask

  // expected stream: controllers in chain order, each queue in its own order
  task automatic build_expected();
    exp_n = 0;
    for (int i = 0; i < N; i++)
      for (int k = 0; k < q_cnt[i]; k++) begin
        exp_w[exp_n] = {11'(i * GROUP + int'(q_ofs[i][k])), COL, q_ts[i][k]};
        exp_n++;
      end
  endtask

  // mode 0: ready high, 1: fixed pattern, 2: pseudo-random
  task automatic run_pass(string req, int mode, int restart_at, output int first_cyc,
                          output int last_cyc);
    int got = 0, n = 0, stall_pend = 0;
    logic [37:0] stall_w = '0;
    logic [15:0] lfsr = 16'hACE1;
    build_expected();
    first_cyc = -1;
    last_cyc = -1;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(done_o == 1'b0, "R7 done cleared by start", 64'(done_o), 64'd0);
    while (!done_o && n < 2000) begin
      n++;
      if (n == restart_at) start_i = 1'b1;
      else start_i = 1'b0;
      case (mode)
        0: hit_ready_i = 1'b1;
        1: hit_ready_i = (n % 3) != 0;
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          hit_ready_i = lfsr[0];
        end
      endcase
      if (stall_pend != 0) begin
        check(hit_valid_o && hit_word_o == stall_w, "R6 held under stall",
              64'(hit_word_o), 64'(stall_w));
        stall_pend = 0;
      end
      if (hit_valid_o && hit_ready_i) begin
        if (got < exp_n)
          check(hit_word_o == exp_w[got], req, 64'(hit_word_o), 64'(exp_w[got]));
        else
          check(1'b0, "R6 extra word", 64'(hit_word_o), 64'(0));
        if (first_cyc < 0) first_cyc = n;
        last_cyc = n;
        got++;
      end else if (hit_valid_o) begin
        stall_pend = 1;
        stall_w = hit_word_o;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    hit_ready_i = 1'b1;
    check(done_o == 1'b1, "R7 done reached", 64'(done_o), 64'd1);
    check(got == exp_n, "R6 word count", 64'(got), 64'(exp_n));
  endtask

  task automatic t_reset();
    check(hit_valid_o == 1'b0, "R8 valid after reset", 64'(hit_valid_o), 64'd0);
    check(ctrl_pop_o == '0, "R8 no pop after reset", 64'(ctrl_pop_o), 64'd0);
    check(done_o == 1'b0, "R8 done after reset", 64'(done_o), 64'd0);
  endtask

  task automatic t_single();
    int f, l;
    clear_queues();
    add_hit(3, 4'd5, 16'h1234);
    run_pass("R1 R2 single hit", 0, -1, f, l);
  endtask

  task automatic t_spread();
    int f, l;
    clear_queues();
    add_hit(0, 4'd0, 16'h0001);
    add_hit(0, 4'd9, 16'h0002);
    add_hit(2, 4'd7, 16'hBEEF);
    add_hit(5, 4'd1, 16'h00F0);
    add_hit(5, 4'd1, 16'h00F1);
    add_hit(5, 4'd14, 16'h00F2);
    add_hit(7, 4'd15, 16'hFFFF);
    run_pass("R3 R2 spread order", 1, -1, f, l);
  endtask

  task automatic t_bounds();
    int f, l;
    clear_queues();
    add_hit(0, 4'd0, 16'h0000);
    add_hit(N-1, 4'(GROUP-1), 16'hFFFF);
    run_pass("R2 R1 group bounds", 0, -1, f, l);
  endtask

  task automatic t_burst();
    int f, l;
    clear_queues();
    for (int k = 0; k < 6; k++) add_hit(4, 4'(k * 3 % GROUP), 16'(16'hA000 + k));
    run_pass("R5 burst words", 0, -1, f, l);
    check(l - f == 5, "R5 consecutive clocks", 64'(l - f), 64'd5);
  endtask

  task automatic t_backpressure();
    int f, l;
    clear_queues();
    for (int i = 0; i < N; i += 2)
      for (int k = 0; k < 4; k++) add_hit(i, 4'(k + i), 16'(i * 256 + k));
    run_pass("R6 random ready", 2, -1, f, l);
  endtask

  task automatic t_restart_ignored();
    int f, l;
    clear_queues();
    for (int k = 0; k < 10; k++) add_hit(1, 4'(k), 16'(16'h5000 + k));
    add_hit(6, 4'd3, 16'h6666);
    run_pass("R7 restart ignored", 1, 5, f, l);
  endtask

  task automatic t_empty_walk();
    int n = 0;
    clear_queues();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && n < 100) begin
      @(negedge clk_i);
      n++;
    end
    check(n == N, "R4 empty walk edges", 64'(n), 64'(N));
    check(hit_valid_o == 1'b0, "R4 nothing emitted", 64'(hit_valid_o), 64'd0);
  endtask

  task automatic t_done_sticky();
    for (int k = 0; k < 5; k++) @(negedge clk_i);
    check(done_o == 1'b1, "R7 done stays high", 64'(done_o), 64'd1);
    check(ctrl_pop_o == '0 && !hit_valid_o, "R7 idle after done",
          64'(ctrl_pop_o), 64'd0);
  endtask

  initial begin
    clear_queues();
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_spread();
    t_bounds();
    t_burst();
    t_backpressure();
    t_restart_ignored();
    t_done_sticky();
    t_empty_walk();
    t_done_sticky();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule